// File: doc/BRIEF.md
# Modulo Circular-Buffer Address Updater

This block holds one address pointer and moves it by a signed step while keeping it inside a circular buffer of programmable length M. Software or a sequencer supplies the modifier value M-1, and the step: plus one, minus one, or a full register value in two's complement. On every strobed cycle the pointer advances by the step. If it would leave the buffer, it wraps once by M.

The buffer's limits are never stored. The lower limit is the current pointer with its k lowest bits cleared, where 2^k is the smallest power of two that is at least M. The upper limit is that lower limit plus M-1. A buffer therefore has to start on a multiple of 2^k. The pointer may start anywhere inside it, and whichever aligned block it sits in defines the buffer. For M = 24, k is 5. Bases fall on multiples of 32, and the pointer circulates over base to base+23.

A load port places the pointer. The combinational next-address output shows the result of the pending step before the clock edge commits it.

Top module: `circ_addr_upd`

## Requirements
- R1: While rst_n is low and after its release, addr_q reads 0 until the first load or update.
- R2: With ld_en and upd_en both low, addr_q keeps its value at the clock edge whatever offset and mod_m1 carry.
- R3: With ld_en high, addr_q takes ld_addr at the next edge. Load wins over a simultaneous upd_en.
- R4: When addr_q+offset lies between the lower and upper limit inclusive, the new pointer is exactly addr_q+offset (offset read as 32-bit two's complement).
- R5: When addr_q+offset exceeds the upper limit, the new pointer is addr_q+offset-M, with M = mod_m1+1.
- R6: When addr_q+offset falls below the lower limit, the new pointer is addr_q+offset+M.
- R7: The lower limit is addr_q with its k low bits forced to zero, where k is the smallest integer with 2^k > mod_m1. For a pointer inside the buffer and |offset| <= M, the result keeps the same upper 32-k bits and has low bits no larger than mod_m1. An offset of exactly +M or -M returns the same address.
- R8: When M is a power of two (mod_m1 = 2^k-1), the pointer wraps over the whole aligned block of 2^k addresses.
- R9: nxt_addr shows the wrapped result for the current addr_q, offset and mod_m1 in the same cycle. With upd_en high and ld_en low, addr_q takes that value at the next edge.
- R10: mod_m1 is 24 bits wide, so M ranges up to 2^24. With mod_m1 = 0xFFFFFF the buffer spans a full 16 Mi-address block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_m1 | input | 24 | Buffer length minus one (M-1) |
| offset | input | 32 | Signed step, two's complement |
| upd_en | input | 1 | Apply the step at the next edge |
| ld_en | input | 1 | Load ld_addr at the next edge |
| ld_addr | input | 32 | Address to load |
| nxt_addr | output | 32 | Wrapped pointer for the pending step |
| addr_q | output | 32 | Current pointer |

## Verification
A load and an update can be requested in the same cycle. The bench raises ld_en and upd_en together with a non-zero step and expects the loaded address, not a stepped one. A single step can also cross a limit in either direction. This is provoked at the top and at the bottom of 24-entry, 16-entry and 2^24-entry buffers, and with steps of exactly plus and minus M. Each result is judged against a behavioural model that wraps the step with integer arithmetic. The model is compared with addr_q on every clock and with nxt_addr before every stepping edge.

// File: rtl/circ_addr_pkg.sv
package circ_addr_pkg;
  localparam int unsigned CA_ADDR_W = 32;
  localparam int unsigned CA_MOD_W  = 24;
  typedef logic [CA_ADDR_W-1:0] ca_addr_t;
endpackage

// File: rtl/circ_mask_gen.sv
// Builds the low-bit mask 2^k-1, where k is the smallest integer with
// 2^k > mod_m1: every bit at or below the highest set bit of mod_m1 is set.
module circ_mask_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MOD_W  = 24
) (
  input  logic [MOD_W-1:0]  mod_m1,
  output logic [ADDR_W-1:0] mask
);
  logic [MOD_W-1:0] fill;

  assign fill[MOD_W-1] = mod_m1[MOD_W-1];
  for (genvar i = 0; i < int'(MOD_W) - 1; i++) begin : g_fill
    assign fill[i] = mod_m1[i] | fill[i+1];
  end

  assign mask = {{(ADDR_W-MOD_W){1'b0}}, fill};
endmodule

// File: rtl/circ_wrap_add.sv
// Adds a signed step to the pointer and folds the result back into the buffer
// [base, base+mod_m1] with at most one correction of M.
module circ_wrap_add #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MOD_W  = 24
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] mask,
  input  logic [MOD_W-1:0]  mod_m1,
  input  logic [ADDR_W-1:0] offset,
  output logic [ADDR_W-1:0] nxt
);
  localparam int unsigned EXT_W = ADDR_W + 2;

  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-1:0] mod_len;
  logic [EXT_W-1:0]  rel_sum;
  logic [EXT_W-1:0]  mod_ext;
  logic              under;
  logic              over;
  logic [ADDR_W-1:0] raw;

  always_comb begin
    rel     = addr & mask;
    mod_len = {{(ADDR_W-MOD_W){1'b0}}, mod_m1} + ADDR_W'(1);
    mod_ext = {{(EXT_W-MOD_W){1'b0}}, mod_m1};
    rel_sum = {2'b00, rel} + {{2{offset[ADDR_W-1]}}, offset};
    under   = rel_sum[EXT_W-1];
    over    = !under && (rel_sum > mod_ext);
    raw     = addr + offset;
    if (over) begin
      nxt = raw - mod_len;
    end else if (under) begin
      nxt = raw + mod_len;
    end else begin
      nxt = raw;
    end
  end
endmodule

// File: rtl/circ_addr_upd.sv
module circ_addr_upd
  import circ_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = CA_ADDR_W,
  parameter int unsigned MOD_W  = CA_MOD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MOD_W-1:0]  mod_m1,
  input  logic [ADDR_W-1:0] offset,
  input  logic              upd_en,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic [ADDR_W-1:0] addr_q
);
  logic [ADDR_W-1:0] low_mask;
  logic [ADDR_W-1:0] ptr_d;
  logic [ADDR_W-1:0] ptr_q;
  logic              ptr_en;

  circ_mask_gen #(.ADDR_W(ADDR_W), .MOD_W(MOD_W)) u_mask (
    .mod_m1 (mod_m1),
    .mask   (low_mask)
  );

  circ_wrap_add #(.ADDR_W(ADDR_W), .MOD_W(MOD_W)) u_wrap (
    .addr   (ptr_q),
    .mask   (low_mask),
    .mod_m1 (mod_m1),
    .offset (offset),
    .nxt    (nxt_addr)
  );

  // Next state: a load has priority over a step.
  always_comb begin
    ptr_en = ld_en | upd_en;
    if (ld_en) begin
      ptr_d = ld_addr;
    end else begin
      ptr_d = nxt_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign addr_q = ptr_q;
endmodule

// File: rtl/circ_addr_upd_chk.sv
module circ_addr_upd_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MOD_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MOD_W-1:0]  mod_m1,
  input logic [ADDR_W-1:0] offset,
  input logic              upd_en,
  input logic              ld_en,
  input logic [ADDR_W-1:0] ld_addr,
  input logic [ADDR_W-1:0] nxt_addr,
  input logic [ADDR_W-1:0] addr_q
);
  logic [ADDR_W-1:0] c_mask;
  logic [ADDR_W-1:0] c_mod;
  logic [ADDR_W-1:0] c_mag;
  logic              c_in_buf;
  logic              c_step_ok;

  always_comb begin
    c_mask = '0;
    for (int i = 0; i < int'(MOD_W); i++) begin
      if (mod_m1[i]) begin
        for (int j = 0; j <= i; j++) begin
          c_mask[j] = 1'b1;
        end
      end
    end
    c_mod     = {{(ADDR_W-MOD_W){1'b0}}, mod_m1};
    c_mag     = offset[ADDR_W-1] ? (~offset + ADDR_W'(1)) : offset;
    c_in_buf  = (addr_q & c_mask) <= c_mod;
    c_step_ok = c_mag <= (c_mod + ADDR_W'(1));
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !upd_en) |=> $stable(addr_q));

  p_load_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (addr_q == $past(ld_addr)));

  p_step_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !ld_en) |=> (addr_q == $past(nxt_addr)));

  p_stay_in_buf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (c_in_buf && c_step_ok) |->
      (((nxt_addr & ~c_mask) == (addr_q & ~c_mask)) && ((nxt_addr & c_mask) <= c_mod)));
endmodule

bind circ_addr_upd circ_addr_upd_chk #(.ADDR_W(ADDR_W), .MOD_W(MOD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mod_m1   (mod_m1),
  .offset   (offset),
  .upd_en   (upd_en),
  .ld_en    (ld_en),
  .ld_addr  (ld_addr),
  .nxt_addr (nxt_addr),
  .addr_q   (addr_q)
);

// File: tb/circ_addr_upd_bench.sv
module circ_addr_upd_bench;
  logic        clk;
  logic        rst_n;
  logic [23:0] mod_m1;
  logic [31:0] offset;
  logic        upd_en;
  logic        ld_en;
  logic [31:0] ld_addr;
  logic [31:0] nxt_addr;
  logic [31:0] addr_q;

  int unsigned n_chk;
  int unsigned n_fail;
  logic [31:0] exp_ptr;
  bit          done;

  circ_addr_upd u_circ_addr_upd (
    .clk(clk), .rst_n(rst_n), .mod_m1(mod_m1), .offset(offset),
    .upd_en(upd_en), .ld_en(ld_en), .ld_addr(ld_addr),
    .nxt_addr(nxt_addr), .addr_q(addr_q)
  );

  initial begin
    clk = 1'b0;
    forever #10ns clk = ~clk;
  end

  // Behavioural reference: integer arithmetic on the aligned block.
  function automatic logic [31:0] ref_next(logic [31:0] a, logic [31:0] off, logic [23:0] md);
    longint m    = longint'(md) + 1;
    longint blk  = 1;
    longint av   = longint'({32'b0, a});
    longint base;
    longint pos;
    while (blk <= longint'(md)) blk = blk * 2;
    base = av - (av % blk);
    pos  = (av % blk) + longint'($signed(off));
    if (pos > longint'(md)) pos = pos - m;
    else if (pos < 0) pos = pos + m;
    return 32'((base + pos) & 64'hFFFF_FFFF);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a negedge; leaves at the following negedge after checking.
  task automatic step(input logic ld, input logic [31:0] la, input logic up,
                      input logic [31:0] off, input logic [23:0] md, input string tag);
    ld_en = ld; ld_addr = la; upd_en = up; offset = off; mod_m1 = md;
    #2ns;
    chk({tag, " nxt_addr R9"}, nxt_addr, ref_next(exp_ptr, off, md));
    if (ld) exp_ptr = la;
    else if (up) exp_ptr = ref_next(exp_ptr, off, md);
    @(posedge clk);
    @(negedge clk);
    chk(tag, addr_q, exp_ptr);
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0; exp_ptr = '0;
    rst_n = 1'b0; mod_m1 = 24'd23; offset = '0; upd_en = 1'b0; ld_en = 1'b0; ld_addr = '0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", addr_q, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", addr_q, 32'd0);

    // M = 24, base 32, limits 32..55
    step(1, 32'd52, 0, 32'd0, 24'd23, "R3 load");
    step(0, 0, 1, 32'd1, 24'd23, "R4 step to 53");
    step(0, 0, 1, 32'd2, 24'd23, "R4 step to upper 55");
    chk("R4 upper limit value", addr_q, 32'd55);
    step(0, 0, 1, 32'd1, 24'd23, "R5 wrap over upper");
    chk("R5 wrapped to base", addr_q, 32'd32);
    step(0, 0, 1, 32'hFFFF_FFFF, 24'd23, "R6 wrap under lower");
    chk("R6 wrapped to upper", addr_q, 32'd55);
    step(1, 32'd34, 0, 32'd0, 24'd23, "R3 load 34");
    step(0, 0, 1, 32'hFFFF_FFFB, 24'd23, "R6 minus five");
    chk("R6 34-5 folds to 53", addr_q, 32'd53);
    step(0, 0, 1, 32'd24, 24'd23, "R7 step of +M");
    chk("R7 +M returns same", addr_q, 32'd53);
    step(0, 0, 1, 32'hFFFF_FFE8, 24'd23, "R7 step of -M");
    chk("R7 -M returns same", addr_q, 32'd53);
    step(0, 0, 0, 32'd7, 24'd5, "R2 hold");
    step(0, 0, 0, 32'hFFFF_FF00, 24'd23, "R2 hold again");
    chk("R2 unchanged", addr_q, 32'd53);
    step(1, 32'd40, 1, 32'd1, 24'd23, "R3 load with step");
    chk("R3 load wins", addr_q, 32'd40);
    step(1, 32'd37, 0, 32'd0, 24'd23, "R4 load 37");
    step(0, 0, 1, 32'd10, 24'd23, "R4 in range +10");
    chk("R4 exact sum", addr_q, 32'd47);
    // Base near the top of the address space
    step(1, 32'hFFFF_FFEA, 0, 32'd0, 24'd23, "R7 load high");
    step(0, 0, 1, 32'd20, 24'd23, "R7 high wrap");
    chk("R7 high block kept", addr_q, 32'hFFFF_FFE6);
    // Power of two length
    step(1, 32'h0000_010F, 0, 32'd0, 24'd15, "R8 load");
    step(0, 0, 1, 32'd1, 24'd15, "R8 wrap up");
    chk("R8 top to base", addr_q, 32'h0000_0100);
    step(0, 0, 1, 32'hFFFF_FFFD, 24'd15, "R8 wrap down");
    chk("R8 base minus three", addr_q, 32'h0000_010D);
    // Largest length
    step(1, 32'h12FF_FFFF, 0, 32'd0, 24'hFF_FFFF, "R10 load");
    step(0, 0, 1, 32'd1, 24'hFF_FFFF, "R10 wrap up");
    chk("R10 block base", addr_q, 32'h1200_0000);
    step(0, 0, 1, 32'hFFFF_FFFF, 24'hFF_FFFF, "R10 wrap down");
    chk("R10 block top", addr_q, 32'h12FF_FFFF);

    // Mixed patterns
    for (int it = 0; it < 150; it++) begin
      logic [23:0] md;
      longint m;
      longint blk;
      logic [31:0] start;
      case ($urandom % 5)
        0: md = 24'd1;
        1: md = 24'd23;
        2: md = 24'd63;
        3: md = 24'd1000;
        default: md = 24'($urandom);
      endcase
      m = longint'(md) + 1;
      blk = 1;
      while (blk <= longint'(md)) blk = blk * 2;
      start = 32'((longint'($urandom) & ~(blk - 1)) + (longint'($urandom) % m));
      step(1, start, 0, 32'd0, md, "R3 mixed load");
      for (int s = 0; s < 3; s++) begin
        longint o = (longint'($urandom) % (2 * m + 1)) - m;
        step(0, 0, 1, 32'(o), md, "R4 R5 R6 R7 mixed step");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule